// File: doc/BRIEF.md
# Vector-Started Program Counter

This block keeps the 16-bit fetch address of a small 8-bit processor. Once reset is released it does not start from a constant. It reads a two-byte start vector from the bottom of memory over a byte-wide read port, one byte per cycle. From the third cycle on, the counter either moves forward by the byte length of the instruction being fetched or takes a branch target supplied by the datapath.

The surrounding core watches `ready`. While it is low, the counter is still collecting its start vector, and any advance or branch request is dropped. Once `ready` is high it stays high until the next reset. From then on the memory port is idle and `pc` always names the next instruction to fetch.

Top module: `pc_vector_seq`

## Requirements
- R1: While `rst_n` is low: `ready` is 0, `pc` is 0000h, `mem_rd` is 1 and `mem_addr` is 0000h.
- R2: In the first cycle after reset release, the block reads address 0000h and that byte becomes `pc[7:0]`. In the second cycle it reads address 0001h and that byte becomes `pc[15:8]`. `ready` rises at the clock edge that captures the second byte.
- R3: While `ready` is 0, `step_en` and `jump_en` have no effect on `pc`. `pc` holds only the vector bytes captured so far.
- R4: With `ready` high and `step_en` high, a `step_len` of 1, 2, 3 or 4 adds that many bytes to `pc` at the next clock edge.
- R5: A `step_len` of 0 or 5 to 7 leaves `pc` unchanged even when `step_en` is high.
- R6: With `ready` high, `jump_en` loads `jump_target` into `pc` at the next clock edge.
- R7: When `jump_en` and `step_en` are both high in the same cycle, the branch target wins.
- R8: An advance past FFFFh wraps modulo 2^16. For example, FFFFh + 3 gives 0002h.
- R9: With `ready` high and no strobe, `pc` holds its value. `mem_rd` is 0 whenever `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rd | output | 1 | Vector read request |
| mem_addr | output | 16 | Vector byte address (0000h or 0001h during the fetch) |
| mem_rdata | input | 8 | Byte returned combinationally for `mem_addr` |
| step_en | input | 1 | Advance strobe |
| step_len | input | 3 | Instruction length in bytes (1 to 4 valid) |
| jump_en | input | 1 | Branch load strobe |
| jump_target | input | 16 | Branch destination |
| pc | output | 16 | Address of the next instruction |
| ready | output | 1 | Start vector fetched |

## Verification
The vector fetch is tried with two different vectors, and strobes are held high throughout the fetch. This separates correct byte order and correct ignoring of strobes from a counter that moves early. The run phase walks every length from 0 to 7, which separates accepted lengths from rejected ones. Combined branch and advance requests expose a wrong priority. Advances that cross FFFFh, both from the vector and from a branch, show whether the wrap is correct.

// File: rtl/pc_vector_seq.sv
module pc_vector_seq #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int LW      = 3,
  parameter int MAX_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          step_en,
  input  logic [LW-1:0] step_len,
  input  logic          jump_en,
  input  logic [AW-1:0] jump_target,
  output logic [AW-1:0] pc,
  output logic          ready
);
  typedef enum logic [1:0] {S_LO, S_HI, S_RUN} phase_t;
  phase_t phase;

  logic len_ok;
  assign len_ok   = (step_len != '0) && (int'(step_len) <= MAX_LEN);
  assign ready    = (phase == S_RUN);
  assign mem_rd   = !ready;
  assign mem_addr = (phase == S_HI) ? AW'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= S_LO;
      pc    <= '0;
    end else begin
      case (phase)
        S_LO: begin
          pc[DW-1:0] <= mem_rdata;
          phase      <= S_HI;
        end
        S_HI: begin
          pc[AW-1:DW] <= mem_rdata[AW-DW-1:0];
          phase       <= S_RUN;
        end
        default: begin
          if (jump_en)
            pc <= jump_target;
          else if (step_en && len_ok)
            pc <= pc + AW'(step_len);
        end
      endcase
    end
  end
endmodule

module pc_vector_seq_chk #(
  parameter int AW = 16,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          step_en,
  input logic [LW-1:0] step_len,
  input logic          jump_en,
  input logic [AW-1:0] jump_target,
  input logic [AW-1:0] pc,
  input logic          ready
);
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R2
  AST_LO_THEN_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr == '0) |=> (mem_rd && mem_addr == AW'(1))); // R2
  AST_NO_RD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_rd); // R9
  AST_JUMP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && jump_en) |=> (pc == $past(jump_target))); // R6
  AST_STEP_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !jump_en && step_en && step_len >= 1 && step_len <= 4)
      |=> (pc == $past(pc) + AW'($past(step_len)))); // R4
  AST_BAD_LEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !jump_en && (step_len == 0 || step_len > 4)) |=> $stable(pc)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !jump_en && !step_en) |=> $stable(pc)); // R9
endmodule

bind pc_vector_seq pc_vector_seq_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .step_en(step_en), .step_len(step_len), .jump_en(jump_en),
  .jump_target(jump_target), .pc(pc), .ready(ready)
);

// File: tb/pc_vector_seq_tb.sv
module pc_vector_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        step_en = 1'b0;
  logic [2:0]  step_len = 3'd0;
  logic        jump_en = 1'b0;
  logic [15:0] jump_target = 16'h0;
  logic [15:0] pc;
  logic        ready;
  logic [15:0] vec = 16'h0;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign mem_rdata = (mem_addr == 16'h0000) ? vec[7:0] :
                     (mem_addr == 16'h0001) ? vec[15:8] : 8'h00;

  pc_vector_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .step_en(step_en), .step_len(step_len),
    .jump_en(jump_en), .jump_target(jump_target), .pc(pc), .ready(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {step_en, jump_en, step_len, jump_target, expected pc}
  localparam int NV = 12;
  localparam logic [36:0] VECS [NV] = '{
    {1'b1, 1'b0, 3'd1, 16'h0000, 16'hFFFD}, // R4
    {1'b1, 1'b0, 3'd2, 16'h0000, 16'hFFFF}, // R4
    {1'b1, 1'b0, 3'd3, 16'h0000, 16'h0002}, // R8
    {1'b0, 1'b1, 3'd0, 16'h1234, 16'h1234}, // R6
    {1'b1, 1'b1, 3'd4, 16'hABCD, 16'hABCD}, // R7
    {1'b1, 1'b0, 3'd4, 16'h0000, 16'hABD1}, // R4
    {1'b1, 1'b0, 3'd0, 16'h0000, 16'hABD1}, // R5
    {1'b1, 1'b0, 3'd7, 16'h0000, 16'hABD1}, // R5
    {1'b0, 1'b0, 3'd2, 16'h0000, 16'hABD1}, // R9
    {1'b1, 1'b0, 3'd5, 16'h0000, 16'hABD1}, // R5
    {1'b0, 1'b1, 3'd6, 16'hFFFF, 16'hFFFF}, // R6
    {1'b1, 1'b0, 3'd4, 16'h0000, 16'h0003}  // R8
  };

  task automatic do_reset(input logic [15:0] v);
    @(negedge clk);
    vec = v;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 ready", ready, 0);
    check("R1 pc", pc, 16'h0000);
    check("R1 mem_rd", mem_rd, 1);
    check("R1 mem_addr", mem_addr, 16'h0000);
    rst_n = 1'b1;
  endtask

  initial begin
    fork
      begin
        // Fetch with strobes held high throughout
        do_reset(16'h5A3C);
        step_en = 1'b1; step_len = 3'd2; jump_en = 1'b1; jump_target = 16'h7777;
        @(negedge clk);
        check("R2 hi addr", mem_addr, 16'h0001);
        check("R2 not ready", ready, 0);
        check("R3 low byte only", pc, 16'h003C);
        @(negedge clk);
        check("R2 ready", ready, 1);
        check("R3 vector pc", pc, 16'h5A3C);
        check("R9 rd low", mem_rd, 0);
        step_en = 1'b0; jump_en = 1'b0;
        @(negedge clk);
        check("R9 hold", pc, 16'h5A3C);

        do_reset(16'hFFFC);
        @(negedge clk);
        @(negedge clk);
        check("R2 ready2", ready, 1);
        check("R2 vector2", pc, 16'hFFFC);
        for (int i = 0; i < NV; i++) begin
          {step_en, jump_en, step_len, jump_target} = VECS[i][36:16];
          @(negedge clk);
          check($sformatf("R4-table row %0d", i), pc, VECS[i][15:0]);
        end
        step_en = 1'b0; jump_en = 1'b0;
        @(negedge clk);
        check("R9 ready sticky", ready, 1);
      end
      begin
        repeat (5000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule